// File: doc/BRIEF.md
# DMA Handshake FIFO Port

This block sits between a host bus and the serial side of a communication controller. It holds two 16-bit FIFOs. The receive FIFO is filled by the serial side and emptied by the host. The transmit FIFO is filled by the host and emptied by the serial side. A DMA engine moves the data using a request/acknowledge pair for each direction.

The receive request is high while the receive FIFO has words to read. The transmit request is high while the transmit FIFO has free slots. While an acknowledge is low, the matching bus strobe goes to the FIFO and not to the normal register decode. Each request drops as soon as the transfer that empties or fills its FIFO begins, so the DMA engine does not start another transfer. Strobes without an acknowledge go to the normal decode outputs, and read data comes from the normal decode input.

The serial side is modelled as a plain push port for receive and a pop port for transmit. Sticky error flags record pushes into a full FIFO and pops from an empty FIFO. The design uses one clock and a synchronous active-high reset. Bus strobes are sampled on that clock.

Top module: `dmafifo_port`

## Requirements
- R1: `rx_dreq` is 1 while the receive FIFO holds at least one word, except in the case of R2, and is 0 while the FIFO is empty.
- R2: When the receive FIFO holds exactly one word, `rx_dreq` goes to 0 combinationally as soon as `bus_rd_n` and `rx_dack_n` are both 0.
- R3: While `rx_dack_n` is 0 and `bus_rd_n` is 0, `bus_rdata` shows the oldest receive word and `norm_rd_n` stays 1. Exactly one word is popped per strobe, in the clock cycle after the strobe or the acknowledge rises.
- R4: `tx_dreq` is 1 while the transmit FIFO has a free slot, except in the case of R5, and is 0 while the FIFO is full.
- R5: When the transmit FIFO has exactly one free slot, `tx_dreq` goes to 0 combinationally as soon as `bus_wr_n` and `tx_dack_n` are both 0.
- R6: While `tx_dack_n` is 0 and `bus_wr_n` is 0, `norm_wr_n` stays 1. One word is pushed per strobe after the strobe ends. The pushed word is the `bus_wdata` value from the last clock cycle in which the acknowledged strobe was low.
- R7: With its acknowledge at 1, a bus strobe is copied to `norm_rd_n` or `norm_wr_n` and leaves both FIFOs unchanged. During such a read, `bus_rdata` equals `norm_rdata`.
- R8: A push into a full FIFO and a pop from an empty FIFO are ignored, and each sets a sticky bit of `err_flags`. Bit 0 is receive push when full, bit 1 is receive pop when empty, bit 2 is transmit push when full, and bit 3 is transmit pop when empty. Only reset clears these bits.
- R9: Both FIFOs keep first-in first-out order. `tx_pop_data` shows the oldest transmit word, `tx_avail` is 1 while that FIFO is not empty, and `tx_pop` removes one word per clock cycle.
- R10: After reset both FIFOs are empty, `rx_dreq` is 0, `tx_dreq` is 1, `tx_avail` is 0 and `err_flags` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_rd_n | input | 1 | Bus read strobe, active low |
| bus_wr_n | input | 1 | Bus write strobe, active low |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Bus read data |
| norm_rdata | input | 16 | Read data from the normal register decode |
| norm_rd_n | output | 1 | Read strobe passed on to the normal decode |
| norm_wr_n | output | 1 | Write strobe passed on to the normal decode |
| rx_dreq | output | 1 | Receive DMA request, active high |
| rx_dack_n | input | 1 | Receive DMA acknowledge, active low |
| tx_dreq | output | 1 | Transmit DMA request, active high |
| tx_dack_n | input | 1 | Transmit DMA acknowledge, active low |
| rx_push | input | 1 | Serial side writes one receive word |
| rx_push_data | input | 16 | Receive word from the serial side |
| tx_pop | input | 1 | Serial side takes one transmit word |
| tx_pop_data | output | 16 | Oldest transmit word |
| tx_avail | output | 1 | Transmit FIFO not empty |
| err_flags | output | 4 | Sticky overflow and underflow flags |

## Verification
The hardest cases to reach are the two early request withdrawals. A request must fall during a transfer that is still in progress, and only when the FIFO is one word from its limit. The bench fills the receive FIFO to a known level through the serial port and drains it with acknowledged reads. For each read it predicts whether that read takes the last word. It checks `rx_dreq` one moment after the strobe falls and before the trailing edge. The transmit side is filled to exactly one free slot by acknowledged writes and checked the same way. Further writes and pops past the limits then confirm that the FIFO contents are unchanged.

// File: rtl/dmafifo_pkg.sv
package dmafifo_pkg;

    localparam int WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    // Sticky error record; packed order puts rx_over at bit 0
    typedef struct packed {
        logic tx_under;
        logic tx_over;
        logic rx_under;
        logic rx_over;
    } err_t;

    function automatic int level_bits(input int depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/dmafifo_store.sv
module dmafifo_store
    import dmafifo_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  word_t push_data,
    input  logic pop,
    output word_t head,
    output logic [level_bits(DEPTH)-1:0] level,
    output logic over_err,
    output logic under_err
);
    localparam int CNT_W = level_bits(DEPTH);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

    word_t mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] level_q;
    logic full, empty, do_push, do_pop;

    assign full    = (level_q == FULL_LVL);
    assign empty   = (level_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];
    assign level   = level_q;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            level_q   <= '0;
            over_err  <= 1'b0;
            under_err <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level_q <= level_q + 1'b1;
                2'b01:   level_q <= level_q - 1'b1;
                default: level_q <= level_q;
            endcase
            if (push && full)  over_err  <= 1'b1;
            if (pop && empty)  under_err <= 1'b1;
        end
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        level_q <= FULL_LVL); // R8
    AST_FULL_PUSH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (level_q == $past(level_q))); // R8
    AST_OVER_STICKY: assert property (@(posedge clk) disable iff (rst)
        over_err |=> over_err); // R8
    AST_UNDER_STICKY: assert property (@(posedge clk) disable iff (rst)
        under_err |=> under_err); // R8

endmodule

// File: rtl/dmafifo_strobe.sv
module dmafifo_strobe (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    input  logic ack_n,
    output logic active,
    output logic fin,
    output logic held
);
    logic held_q;

    assign active = !strobe_n && !ack_n;
    assign fin    = held_q && !active;
    assign held   = held_q;

    always_ff @(posedge clk) begin
        if (rst) held_q <= 1'b0;
        else     held_q <= active;
    end

endmodule

// File: rtl/dmafifo_port.sv
module dmafifo_port
    import dmafifo_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_rd_n,
    input  logic                bus_wr_n,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [WORD_W-1:0]   norm_rdata,
    output logic                norm_rd_n,
    output logic                norm_wr_n,
    output logic                rx_dreq,
    input  logic                rx_dack_n,
    output logic                tx_dreq,
    input  logic                tx_dack_n,
    input  logic                rx_push,
    input  logic [WORD_W-1:0]   rx_push_data,
    input  logic                tx_pop,
    output logic [WORD_W-1:0]   tx_pop_data,
    output logic                tx_avail,
    output logic [3:0]          err_flags
);
    localparam int CNT_W = level_bits(DEPTH);
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE_LEFT = CNT_W'(DEPTH - 1);

    logic rx_active, rx_fin, rx_held;
    logic tx_active, tx_fin, tx_held;
    logic [CNT_W-1:0] rx_level, tx_level;
    word_t rx_head, tx_head, wdata_q;
    err_t  errs;

    dmafifo_strobe u_rx_strobe (
        .clk(clk), .rst(rst), .strobe_n(bus_rd_n), .ack_n(rx_dack_n),
        .active(rx_active), .fin(rx_fin), .held(rx_held)
    );

    dmafifo_strobe u_tx_strobe (
        .clk(clk), .rst(rst), .strobe_n(bus_wr_n), .ack_n(tx_dack_n),
        .active(tx_active), .fin(tx_fin), .held(tx_held)
    );

    // Write data captured every cycle the acknowledged write is low
    always_ff @(posedge clk) begin
        if (rst)            wdata_q <= '0;
        else if (tx_active) wdata_q <= bus_wdata;
    end

    dmafifo_store #(.DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst(rst),
        .push(rx_push), .push_data(rx_push_data),
        .pop(rx_fin), .head(rx_head), .level(rx_level),
        .over_err(errs.rx_over), .under_err(errs.rx_under)
    );

    dmafifo_store #(.DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst(rst),
        .push(tx_fin), .push_data(wdata_q),
        .pop(tx_pop), .head(tx_head), .level(tx_level),
        .over_err(errs.tx_over), .under_err(errs.tx_under)
    );

    // Requests withdraw at the start of the final transfer
    assign rx_dreq = (rx_level != '0) && !((rx_level == CNT_W'(1)) && rx_active);
    assign tx_dreq = (tx_level != FULL_LVL) && !((tx_level == ONE_LEFT) && tx_active);

    assign bus_rdata   = rx_dack_n ? norm_rdata : rx_head;
    assign norm_rd_n   = bus_rd_n | ~rx_dack_n;
    assign norm_wr_n   = bus_wr_n | ~tx_dack_n;
    assign tx_pop_data = tx_head;
    assign tx_avail    = (tx_level != '0);
    assign err_flags   = errs;

    AST_RXREQ_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (rx_level == '0) |-> !rx_dreq); // R1
    AST_TXREQ_FULL: assert property (@(posedge clk) disable iff (rst)
        (tx_level == FULL_LVL) |-> !tx_dreq); // R4
    AST_RX_POP_STEP: assert property (@(posedge clk) disable iff (rst)
        (rx_fin && rx_held && (rx_level != '0) && !rx_push)
        |=> (rx_level == $past(rx_level) - 1'b1)); // R3
    AST_TX_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
        (tx_fin && tx_held && (tx_level != FULL_LVL) && !tx_pop)
        |=> (tx_level == $past(tx_level) + 1'b1)); // R6
    AST_NORM_RD_GATED: assert property (@(posedge clk) disable iff (rst)
        rx_active |-> norm_rd_n); // R3

endmodule

// File: tb/dmafifo_port_tb.sv
module dmafifo_port_tb_top;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_rd_n = 1'b1, bus_wr_n = 1'b1;
    logic [15:0] bus_wdata = '0, norm_rdata = 16'h5A5A, rx_push_data = '0;
    logic rx_dack_n = 1'b1, tx_dack_n = 1'b1, rx_push = 1'b0, tx_pop = 1'b0;
    logic [15:0] bus_rdata, tx_pop_data;
    logic norm_rd_n, norm_wr_n, rx_dreq, tx_dreq, tx_avail;
    logic [3:0] err_flags;

    int total = 0, fails = 0, rx_cnt = 0, tx_cnt = 0;
    bit done = 0;
    logic [15:0] rxq[$], txq[$];

    always #10 clk = ~clk;

    dmafifo_port #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .norm_rdata(norm_rdata),
        .norm_rd_n(norm_rd_n), .norm_wr_n(norm_wr_n), .rx_dreq(rx_dreq),
        .rx_dack_n(rx_dack_n), .tx_dreq(tx_dreq), .tx_dack_n(tx_dack_n),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .tx_pop(tx_pop),
        .tx_pop_data(tx_pop_data), .tx_avail(tx_avail), .err_flags(err_flags)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    // Driver: serial receive push; scoreboard records accepted words
    task automatic serial_push(input logic [15:0] d);
        @(negedge clk);
        rx_push = 1'b1; rx_push_data = d;
        if (rx_cnt < DEPTH) begin rxq.push_back(d); rx_cnt++; end
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    // Acknowledged read; monitor compares against scoreboard head
    task automatic dma_read();
        @(negedge clk);
        bus_rd_n = 1'b0; rx_dack_n = 1'b0;
        #1;
        if (rx_cnt > 0) check("R3 rd data", bus_rdata, rxq[0]);
        check("R3 norm_rd_n held", norm_rd_n, 1'b1);
        if (rx_cnt == 1) check("R2 rx_dreq early drop", rx_dreq, 1'b0);
        else if (rx_cnt > 1) check("R1 rx_dreq during read", rx_dreq, 1'b1);
        @(negedge clk);
        @(negedge clk);
        bus_rd_n = 1'b1; rx_dack_n = 1'b1;
        if (rx_cnt > 0) begin void'(rxq.pop_front()); rx_cnt--; end
        @(negedge clk);
        #1;
    endtask

    task automatic dma_write(input logic [15:0] d);
        @(negedge clk);
        bus_wr_n = 1'b0; tx_dack_n = 1'b0; bus_wdata = d;
        #1;
        check("R6 norm_wr_n held", norm_wr_n, 1'b1);
        if (tx_cnt == DEPTH - 1) check("R5 tx_dreq early drop", tx_dreq, 1'b0);
        else if (tx_cnt < DEPTH - 1) check("R4 tx_dreq during write", tx_dreq, 1'b1);
        @(negedge clk);
        @(negedge clk);
        bus_wr_n = 1'b1; tx_dack_n = 1'b1; bus_wdata = 16'hDEAD;
        if (tx_cnt < DEPTH) begin txq.push_back(d); tx_cnt++; end
        @(negedge clk);
        #1;
    endtask

    task automatic serial_pop();
        @(negedge clk);
        tx_pop = 1'b1;
        #1;
        if (tx_cnt > 0) begin
            check("R9 tx_pop_data order", tx_pop_data, txq.pop_front());
            tx_cnt--;
        end
        @(negedge clk);
        tx_pop = 1'b0;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10 rx_dreq", rx_dreq, 1'b0);
        check("R10 tx_dreq", tx_dreq, 1'b1);
        check("R10 tx_avail", tx_avail, 1'b0);
        check("R10 err_flags", err_flags, 4'b0000);

        serial_push(16'h1111); serial_push(16'h2222); serial_push(16'h3333);
        #1;
        check("R1 rx_dreq with data", rx_dreq, 1'b1);

        // Unacknowledged read goes to normal decode, FIFO untouched
        @(negedge clk);
        bus_rd_n = 1'b0;
        #1;
        check("R7 bus_rdata normal", bus_rdata, 16'h5A5A);
        check("R7 norm_rd_n pass", norm_rd_n, 1'b0);
        @(negedge clk); @(negedge clk);
        bus_rd_n = 1'b1;
        @(negedge clk);
        #1;
        check("R7 rx_dreq after plain read", rx_dreq, 1'b1);

        dma_read(); dma_read(); dma_read();
        check("R1 rx_dreq empty", rx_dreq, 1'b0);
        check("R8 no error yet", err_flags, 4'b0000);

        dma_read();
        check("R8 rx pop empty flag", err_flags, 4'b0010);

        dma_write(16'hA001); dma_write(16'hA002); dma_write(16'hA003); dma_write(16'hA004);
        check("R4 tx_dreq full", tx_dreq, 1'b0);
        check("R9 tx_avail", tx_avail, 1'b1);
        dma_write(16'hBAD0);
        check("R8 tx push full flag", err_flags, 4'b0110);

        serial_pop(); serial_pop(); serial_pop(); serial_pop();
        check("R9 tx empty", tx_avail, 1'b0);
        check("R4 tx_dreq after drain", tx_dreq, 1'b1);

        // Unacknowledged write reaches normal decode only
        @(negedge clk);
        bus_wr_n = 1'b0; bus_wdata = 16'h7777;
        #1;
        check("R7 norm_wr_n pass", norm_wr_n, 1'b0);
        @(negedge clk); @(negedge clk);
        bus_wr_n = 1'b1;
        @(negedge clk); @(negedge clk);
        #1;
        check("R7 tx untouched", tx_avail, 1'b0);

        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
        #1;
        check("R8 tx pop empty flag", err_flags, 4'b1110);

        for (int i = 0; i < DEPTH + 1; i++) serial_push(16'hC000 + 16'(i));
        #1;
        check("R8 rx push full flag", err_flags, 4'b1111);
        for (int i = 0; i < DEPTH; i++) dma_read();
        check("R1 rx drained", rx_dreq, 1'b0);
        check("R8 flags sticky", err_flags, 4'b1111);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10 reset clears flags", err_flags, 4'b0000);
        finish_run();
    end

endmodule